// File: doc/BRIEF.md
# Halt and Active-Halt Power Controller

This block decides what the clock tree of a small 8-bit core does after the core executes its HALT instruction. Instruction decode pulses a halt request. Two timer configuration inputs then pick one of two low-power states:

- **Active-halt** keeps the oscillator and one wake-up timer running. The timer serves as a time base.
- **Plain halt** gates every clock, including the oscillator.

The block drives registered clock-enable outputs for the CPU, the internally clocked peripherals, the oscillator and the wake-up timer.

Wake-up follows one of two paths:

- **Timer interrupt in active-halt.** The CPU clock restarts on the next cycle, and the controller issues a vector-fetch request for that interrupt's vector.
- **Reset, or an external interrupt in plain halt.** The controller first holds the CPU for a fixed start-up delay of 256 cycles, and only then issues the vector fetch.

The block also owns the core's interrupt-mask bit. It clears the bit on entry to either low-power state. It sets the bit when it starts servicing a wake interrupt, and it puts back the saved value when the core reports that the condition codes have been restored. A watchdog option can turn a halt attempt into a watchdog reset request.

Top module: `haltPowerCtrl`

## Requirements
- R1: A halt request in the running state enters active-halt when `tbIntEn` is 1. It also enters active-halt when `ovfIntEn` is 1 and `arClkSel` equals 2'b01 (the code for the clock that keeps running). Any other combination enters plain halt.
- R2: In active-halt, `cpuClkEn`=0, `periphClkEn`=0, `oscEn`=1 and `timerClkEn`=1. Entering either low-power state clears `iBit` to 0. All enable outputs are registered and change one cycle after the edge that causes the change.
- R3: If `tbIrq` or `ovfIrq` is already high when active-halt is entered, the controller spends exactly one cycle halted. It then shows `vecFetch`=1.
- R4: In active-halt, `tbIrq` causes a one-cycle `vecFetch` with `vecSel`=1 in the next cycle, with the CPU clock enabled at once and no delay. `ovfIrq` does the same with `vecSel`=2. When both are high, `tbIrq` wins.
- R5: In active-halt, `extIrq` has no effect: the enables stay in the active-halt pattern and `vecFetch` stays 0.
- R6: After `rst` is released, exactly 256 cycles pass with the CPU held off before `vecFetch`=1 appears with `vecSel`=0. In the cycle after the fetch, the block is back in the running state with all enables at 1.
- R7: In plain halt, all four enables are 0, and `tbIrq` and `ovfIrq` are ignored. `extIrq` starts the 256-cycle delay, which ends in a vector fetch with `vecSel`=3.
- R8: A halt request while `wdgActive`=1 and `wdgHaltOpt`=1 gives a one-cycle `wdgRstReq` pulse, and the block stays running. With `wdgHaltOpt`=0, the halt proceeds and `wdgRstReq` stays 0.
- R9: An interrupt vector fetch (`vecSel` not 0) comes with `ccSave`=1 and `iBit`=1. A later `ccRestore` pulse returns `iBit` to its value just before the service started.
- R10: A high `rst` at a clock edge forces the start-up delay from any state. During reset and during the delay, `iBit`=1 after reset, `cpuClkEn`=0, `periphClkEn`=0, `timerClkEn`=0 and `oscEn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| haltReq | input | 1 | HALT instruction executed strobe |
| tbIntEn | input | 1 | Time-base timer interrupt enable |
| ovfIntEn | input | 1 | Auto-reload timer overflow interrupt enable |
| arClkSel | input | 2 | Auto-reload timer clock select, 2'b01 = running clock |
| tbIrq | input | 1 | Time-base timer interrupt request |
| ovfIrq | input | 1 | Auto-reload timer overflow interrupt request |
| extIrq | input | 1 | Any other interrupt request |
| wdgActive | input | 1 | Watchdog is counting |
| wdgHaltOpt | input | 1 | Watchdog option: halt causes watchdog reset |
| ccRestore | input | 1 | Condition codes recovered from the stack |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Internal peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| timerClkEn | output | 1 | Wake-up timer clock enable |
| iBit | output | 1 | Interrupt-mask bit |
| vecFetch | output | 1 | One-cycle vector-fetch request |
| vecSel | output | 2 | Vector: 0 reset, 1 time base, 2 overflow, 3 external |
| ccSave | output | 1 | Push condition codes strobe |
| wdgRstReq | output | 1 | Watchdog reset request pulse |

## Verification
A state register stuck in, or wrongly entering, a low-power state shows up in the enable pattern one cycle later, because each low-power state has its own combination of the four enables. A delay counter that is loaded wrongly or stops early moves the vector fetch away from the 256th cycle. The bench measures that position exactly after reset and after an external wake. A mishandled mask bit shows up on `iBit` on the cycle of the fetch, or on the cycle after a restore.

// File: rtl/haltPwrPkg.sv
package haltPwrPkg;

  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_HALT   = 3'd1,
    PS_AHALT  = 3'd2,
    PS_RSTDLY = 3'd3,
    PS_VFETCH = 3'd4
  } pwrState_t;

  typedef enum logic [1:0] {
    VEC_RESET  = 2'd0,
    VEC_TBASE  = 2'd1,
    VEC_ARTOVF = 2'd2,
    VEC_EXT    = 2'd3
  } wakeVec_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    pwrState_t nextState;
    logic      loadDelay;
    logic      countDelay;
    logic      fetchReq;
    wakeVec_t  fetchVec;
    logic      svcStart;
    logic      clearMask;
    logic      wdgHit;
  } pwrStrobe_t;

endpackage

// File: rtl/haltPwrCtrl.sv
module haltPwrCtrl
  import haltPwrPkg::*;
#(
  parameter int CLKSEL_W = 2,
  parameter logic [CLKSEL_W-1:0] RUN_CLKSEL = 2'b01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                haltReq,
  input  logic                tbIntEn,
  input  logic                ovfIntEn,
  input  logic [CLKSEL_W-1:0] arClkSel,
  input  logic                tbIrq,
  input  logic                ovfIrq,
  input  logic                extIrq,
  input  logic                wdgActive,
  input  logic                wdgHaltOpt,
  input  logic                delayDone,
  output pwrStrobe_t          strobe
);

  pwrState_t state;
  wakeVec_t  pendVec;
  wakeVec_t  nextPend;
  logic      ahSel;

  assign ahSel = tbIntEn | (ovfIntEn & (arClkSel == RUN_CLKSEL));

  always_comb begin
    strobe            = '0;
    strobe.nextState  = state;
    strobe.fetchVec   = pendVec;
    strobe.countDelay = (state == PS_RSTDLY);
    nextPend          = pendVec;
    if (rst) begin
      strobe.nextState = PS_RSTDLY;
      strobe.loadDelay = 1'b1;
      nextPend         = VEC_RESET;
    end else begin
      case (state)
        PS_RUN: begin
          if (haltReq) begin
            if (wdgActive && wdgHaltOpt) begin
              strobe.wdgHit = 1'b1;
            end else begin
              strobe.clearMask = 1'b1;
              strobe.nextState = ahSel ? PS_AHALT : PS_HALT;
            end
          end
        end
        PS_AHALT: begin
          if (tbIrq) begin
            strobe.nextState = PS_VFETCH;
            strobe.fetchReq  = 1'b1;
            strobe.fetchVec  = VEC_TBASE;
          end else if (ovfIrq) begin
            strobe.nextState = PS_VFETCH;
            strobe.fetchReq  = 1'b1;
            strobe.fetchVec  = VEC_ARTOVF;
          end
        end
        PS_HALT: begin
          if (extIrq) begin
            strobe.nextState = PS_RSTDLY;
            strobe.loadDelay = 1'b1;
            nextPend         = VEC_EXT;
          end
        end
        PS_RSTDLY: begin
          if (delayDone) begin
            strobe.nextState = PS_VFETCH;
            strobe.fetchReq  = 1'b1;
            strobe.fetchVec  = pendVec;
          end
        end
        PS_VFETCH: strobe.nextState = PS_RUN;
        default:   strobe.nextState = PS_RUN;
      endcase
    end
    strobe.svcStart = strobe.fetchReq && (strobe.fetchVec != VEC_RESET);
  end

  always_ff @(posedge clk) begin
    state   <= strobe.nextState;
    pendVec <= nextPend;
  end

  AST_PEND_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state == PS_AHALT && (tbIrq || ovfIrq)) |=> (state == PS_VFETCH)); // R3

  AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == PS_AHALT && !tbIrq && !ovfIrq) |=> (state == PS_AHALT || rst)); // R5

endmodule

// File: rtl/haltPwrDatapath.sv
module haltPwrDatapath
  import haltPwrPkg::*;
#(
  parameter int DELAY_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  pwrStrobe_t strobe,
  input  logic       ccRestore,
  output logic       delayDone,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       oscEn,
  output logic       timerClkEn,
  output logic       iBit,
  output logic       vecFetch,
  output logic [1:0] vecSel,
  output logic       ccSave,
  output logic       wdgRstReq
);

  localparam int CNT_W = $clog2(DELAY_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] delayCnt;
  logic [3:0]       enNext;  // {cpu, periph, osc, timer}
  logic             savedI;

  assign delayDone = (delayCnt == CNT_LAST);

  always_comb begin
    case (strobe.nextState)
      PS_RUN:    enNext = 4'b1111;
      PS_VFETCH: enNext = 4'b1111;
      PS_AHALT:  enNext = 4'b0011;
      PS_HALT:   enNext = 4'b0000;
      PS_RSTDLY: enNext = 4'b0010;
      default:   enNext = 4'b1111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.loadDelay) begin
      delayCnt <= '0;
    end else if (strobe.countDelay && !delayDone) begin
      delayCnt <= delayCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    {cpuClkEn, periphClkEn, oscEn, timerClkEn} <= enNext;
    vecFetch  <= strobe.fetchReq;
    vecSel    <= strobe.fetchVec;
    ccSave    <= strobe.svcStart;
    wdgRstReq <= strobe.wdgHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iBit   <= 1'b1;
      savedI <= 1'b1;
    end else if (strobe.svcStart) begin
      savedI <= iBit;
      iBit   <= 1'b1;
    end else if (strobe.clearMask) begin
      iBit <= 1'b0;
    end else if (ccRestore) begin
      iBit <= savedI;
    end
  end

  AST_SVC_MASK: assert property (@(posedge clk) disable iff (rst)
    (vecFetch && vecSel != 2'd0) |-> (iBit && ccSave)); // R9

endmodule

// File: rtl/haltPowerCtrl.sv
module haltPowerCtrl
  import haltPwrPkg::*;
#(
  parameter int DELAY_CYCLES = 256,
  parameter int CLKSEL_W = 2,
  parameter logic [CLKSEL_W-1:0] RUN_CLKSEL = 2'b01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                haltReq,
  input  logic                tbIntEn,
  input  logic                ovfIntEn,
  input  logic [CLKSEL_W-1:0] arClkSel,
  input  logic                tbIrq,
  input  logic                ovfIrq,
  input  logic                extIrq,
  input  logic                wdgActive,
  input  logic                wdgHaltOpt,
  input  logic                ccRestore,
  output logic                cpuClkEn,
  output logic                periphClkEn,
  output logic                oscEn,
  output logic                timerClkEn,
  output logic                iBit,
  output logic                vecFetch,
  output logic [1:0]          vecSel,
  output logic                ccSave,
  output logic                wdgRstReq
);

  localparam int RUN_W = $clog2(DELAY_CYCLES) + 2;

  pwrStrobe_t strobe;
  logic       delayDone;

  haltPwrCtrl #(.CLKSEL_W(CLKSEL_W), .RUN_CLKSEL(RUN_CLKSEL)) ctrl (
    .clk(clk), .rst(rst), .haltReq(haltReq), .tbIntEn(tbIntEn),
    .ovfIntEn(ovfIntEn), .arClkSel(arClkSel), .tbIrq(tbIrq),
    .ovfIrq(ovfIrq), .extIrq(extIrq), .wdgActive(wdgActive),
    .wdgHaltOpt(wdgHaltOpt), .delayDone(delayDone), .strobe(strobe)
  );

  haltPwrDatapath #(.DELAY_CYCLES(DELAY_CYCLES)) dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .ccRestore(ccRestore),
    .delayDone(delayDone), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .oscEn(oscEn), .timerClkEn(timerClkEn), .iBit(iBit),
    .vecFetch(vecFetch), .vecSel(vecSel), .ccSave(ccSave),
    .wdgRstReq(wdgRstReq)
  );

  // Length of the current start-up delay, as seen at the enable outputs
  logic             inDelay;
  logic [RUN_W-1:0] dlyRun;

  assign inDelay = oscEn && !cpuClkEn && !timerClkEn && !periphClkEn;

  always_ff @(posedge clk) begin
    if (rst || !inDelay) dlyRun <= '0;
    else                 dlyRun <= dlyRun + RUN_W'(1);
  end

  AST_DELAY_LEN: assert property (@(posedge clk) disable iff (rst)
    (vecFetch && $past(inDelay)) |-> (dlyRun == RUN_W'(DELAY_CYCLES))); // R6

  AST_AH_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!cpuClkEn && timerClkEn) |-> (oscEn && !periphClkEn)); // R2

  AST_WDG_STAYS: assert property (@(posedge clk) disable iff (rst)
    wdgRstReq |-> (cpuClkEn && periphClkEn)); // R8

endmodule

// File: tb/haltPowerCtrl_test.sv
module haltPowerCtrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DLY = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic haltReq = 0, tbIntEn = 0, ovfIntEn = 0;
  logic [1:0] arClkSel = 2'b00;
  logic tbIrq = 0, ovfIrq = 0, extIrq = 0;
  logic wdgActive = 0, wdgHaltOpt = 0, ccRestore = 0;
  logic cpuClkEn, periphClkEn, oscEn, timerClkEn, iBit;
  logic vecFetch, ccSave, wdgRstReq;
  logic [1:0] vecSel;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  haltPowerCtrl uut (
    .clk(clk), .rst(rst), .haltReq(haltReq), .tbIntEn(tbIntEn),
    .ovfIntEn(ovfIntEn), .arClkSel(arClkSel), .tbIrq(tbIrq),
    .ovfIrq(ovfIrq), .extIrq(extIrq), .wdgActive(wdgActive),
    .wdgHaltOpt(wdgHaltOpt), .ccRestore(ccRestore),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn),
    .timerClkEn(timerClkEn), .iBit(iBit), .vecFetch(vecFetch),
    .vecSel(vecSel), .ccSave(ccSave), .wdgRstReq(wdgRstReq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // enables packed as {cpu, periph, osc, timer}
  task automatic checkEn(input string req, input int exp);
    check(req, "enables", int'({cpuClkEn, periphClkEn, oscEn, timerClkEn}), exp);
  endtask

  // Count cycles until vecFetch, starting at the negedge after the delay entry edge
  task automatic waitFetch(input string req, input int expVec);
    int n = 0;
    while (!vecFetch && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(req, "delay cycles", n, DLY);
    check(req, "vecSel", int'(vecSel), expVec);
    @(negedge clk);
    checkEn(req, 4'b1111);
    check(req, "vecFetch low after fetch", int'(vecFetch), 0);
  endtask

  task automatic tResetStart;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkEn("R10", 4'b0010);
    check("R10", "iBit at reset", int'(iBit), 1);
    check("R10", "vecFetch at reset", int'(vecFetch), 0);
    rst = 1'b0;
    waitFetch("R6", 0);
  endtask

  task automatic tActiveHaltTb;
    tbIntEn = 1'b1;
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    checkEn("R1", 4'b0011);
    checkEn("R2", 4'b0011);
    check("R2", "iBit cleared on entry", int'(iBit), 0);
    extIrq = 1'b1;
    repeat (3) @(negedge clk);
    checkEn("R5", 4'b0011);
    check("R5", "no fetch on extIrq", int'(vecFetch), 0);
    extIrq = 1'b0;
    tbIrq = 1'b1;
    ovfIrq = 1'b1;
    @(negedge clk);
    tbIrq = 1'b0;
    ovfIrq = 1'b0;
    check("R4", "vecFetch", int'(vecFetch), 1);
    check("R4", "vecSel tb priority", int'(vecSel), 1);
    check("R4", "cpu clock back", int'(cpuClkEn), 1);
    check("R9", "ccSave", int'(ccSave), 1);
    check("R9", "iBit during service", int'(iBit), 1);
    @(negedge clk);
    check("R4", "single fetch pulse", int'(vecFetch), 0);
    check("R9", "ccSave pulse ends", int'(ccSave), 0);
    ccRestore = 1'b1;
    @(negedge clk);
    ccRestore = 1'b0;
    check("R9", "iBit restored", int'(iBit), 0);
    tbIntEn = 1'b0;
  endtask

  task automatic tPendingOvf;
    ovfIntEn = 1'b1;
    arClkSel = 2'b01;
    ovfIrq = 1'b1;
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    checkEn("R3", 4'b0011);
    @(negedge clk);
    ovfIrq = 1'b0;
    check("R3", "wake next cycle", int'(vecFetch), 1);
    check("R4", "vecSel overflow", int'(vecSel), 2);
    @(negedge clk);
    checkEn("R4", 4'b1111);
  endtask

  task automatic tPlainHalt;
    ovfIntEn = 1'b1;
    arClkSel = 2'b10;
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    checkEn("R1", 4'b0000);
    check("R7", "iBit cleared", int'(iBit), 0);
    tbIrq = 1'b1;
    ovfIrq = 1'b1;
    repeat (3) @(negedge clk);
    checkEn("R7", 4'b0000);
    check("R7", "timer irq ignored", int'(vecFetch), 0);
    tbIrq = 1'b0;
    ovfIrq = 1'b0;
    extIrq = 1'b1;
    @(negedge clk);
    extIrq = 1'b0;
    checkEn("R7", 4'b0010);
    waitFetch("R7", 3);
    ovfIntEn = 1'b0;
    arClkSel = 2'b00;
  endtask

  task automatic tWatchdog;
    tbIntEn = 1'b1;
    wdgActive = 1'b1;
    wdgHaltOpt = 1'b1;
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    check("R8", "wdgRstReq", int'(wdgRstReq), 1);
    checkEn("R8", 4'b1111);
    @(negedge clk);
    check("R8", "wdgRstReq one cycle", int'(wdgRstReq), 0);
    wdgHaltOpt = 1'b0;
    haltReq = 1'b1;
    @(negedge clk);
    haltReq = 1'b0;
    check("R8", "no reset with option clear", int'(wdgRstReq), 0);
    checkEn("R8", 4'b0011);
    wdgActive = 1'b0;
  endtask

  task automatic tResetInHalt;
    // still in active-halt from tWatchdog
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkEn("R10", 4'b0010);
    check("R10", "iBit set by reset", int'(iBit), 1);
    waitFetch("R10", 0);
    tbIntEn = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    tResetStart();
    tActiveHaltTb();
    tPendingOvf();
    tPlainHalt();
    tWatchdog();
    tResetInHalt();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule